// File: doc/BRIEF.md
# Serial Converter Shared-Line Controller

This block is the host side of a link to a 12-bit serial analog-to-digital converter whose data input and data output share one wire. A single-cycle `start` request pulls chip select low. The block then produces a slow serial clock by dividing the system clock, and sends a four-bit command on the shared wire. The command holds a start marker, the single-ended/differential choice, the channel (odd/sign) choice and a most-significant-first request. After the fourth command bit the block stops driving the wire. The converter uses the next clock as a null bit and then returns its result, most significant bit first.

Chip select goes high again one system clock after the last result bit is sampled. This keeps the converter's powered time short, and no clock edges are ever made for the least-significant-first copy that the converter would otherwise send. The result is offered with a one-cycle strobe. A guard interval then keeps chip select high for a minimum time before another request is taken.

Top module: `adc_link_ctrl`

## Requirements
- R1: After reset `adc_cs_n`=1, `adc_sclk`=0, `sdio_oe`=0, `busy`=0 and `result_valid`=0.
- R2: A `start` sampled high while idle drives `adc_cs_n` low and `busy` high in the next cycle, with `adc_sclk` low.
- R3: While `sdio_oe` is high, `sdio_out` carries the command bits 1, `cfg_single`, `cfg_odd`, 1, in that order. The first bit appears with chip select low, and each following bit changes on a falling serial-clock edge, so the converter sees command bit k at rising edge k.
- R4: Every serial-clock level lasts HALF system clocks, with HALF = max(2, ceil(SYS_CLK_KHZ / (2·min(SCLK_KHZ,200)))). The serial clock therefore never exceeds 200 kHz, even when a faster SCLK_KHZ is requested.
- R5: `sdio_oe` falls one system clock after the fourth rising serial-clock edge, which is before the fourth falling edge. It stays low until chip select rises.
- R6: The rising edge after the null bit (edge 5) is not captured. Rising edges 6 to 17 sample `sdio_in` into `result`, bit 11 first and bit 0 last.
- R7: There are exactly 17 rising serial-clock edges per transaction. `adc_cs_n` rises and `adc_sclk` returns low one system clock after rising edge 17.
- R8: `result_valid` is high for exactly one cycle, in the cycle in which `adc_cs_n` rises. `result` holds the captured word in that cycle.
- R9: A `start` sampled while `busy` is high has no effect on chip select or the serial clock.
- R10: After chip select rises, it stays high and `busy` stays high for GUARD_CYC system clocks. A `start` during that time is ignored, and the first idle cycle accepts a request.
- R11: `cfg_single` and `cfg_odd` are captured when a request is accepted. Changing them later has no effect on the command sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Conversion request, taken only when idle |
| cfg_single | input | 1 | 1 = single-ended, 0 = differential |
| cfg_odd | input | 1 | Channel / polarity select bit |
| busy | output | 1 | High from acceptance to the end of the guard interval |
| result | output | 12 | Captured conversion word |
| result_valid | output | 1 | One-cycle strobe for `result` |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Serial clock to the converter |
| sdio_out | output | 1 | Value driven onto the shared data wire |
| sdio_oe | output | 1 | Drive enable for the shared data wire |
| sdio_in | input | 1 | Value observed on the shared data wire |

## Verification
Two functions can meet in one cycle: the end of the guard interval and a new request. The bench holds `start` high across a whole transaction and through the following ones. The first idle cycle must therefore accept the request at once, while every guard cycle before it must reject it. A cycle-accurate reference predicts the exact cycle of each chip-select fall, so a request taken one cycle early or one cycle late shows up as a mismatch on `adc_cs_n` and `busy`. In the same way, the strobe and the chip-select rise must coincide, and this is judged in every cycle.

// File: rtl/adc_link_pkg.sv
package adc_link_pkg;

    // Sequencer states
    typedef enum logic [1:0] {
        LINK_IDLE  = 2'd0,
        LINK_RUN   = 2'd1,
        LINK_GUARD = 2'd2
    } link_state_e;

    localparam int CMD_LEN       = 4;    // command bits sent by the host
    localparam int NULL_LEN      = 1;    // idle bit after the turnaround
    localparam int SCLK_CEIL_KHZ = 200;  // fastest allowed serial clock

    // System clocks per serial-clock level, rounded up, never below two
    function automatic int half_cycles(input int sys_khz, input int want_khz);
        int lim;
        int h;
        lim = (want_khz > SCLK_CEIL_KHZ) ? SCLK_CEIL_KHZ : want_khz;
        if (lim < 1) lim = 1;
        h = (sys_khz + 2 * lim - 1) / (2 * lim);
        return (h < 2) ? 2 : h;
    endfunction

endpackage

// File: rtl/adc_link_tick.sv
module adc_link_tick #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF > 2) ? $clog2(HALF) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tick_regs_t;

    tick_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!run) begin
            r_d.cnt = '0;
        end else if (r_q.cnt == CW'(HALF - 1)) begin
            r_d.cnt = '0;
        end else begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign tick = run && (r_q.cnt == CW'(HALF - 1));

endmodule

// File: rtl/adc_link_shreg.sv
module adc_link_shreg #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    input  logic             shift,
    input  logic             sin,
    output logic [WIDTH-1:0] q
);
    typedef struct packed {
        logic [WIDTH-1:0] bits;
    } sh_regs_t;

    sh_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (load) begin
            r_d.bits = load_val;
        end else if (shift) begin
            r_d.bits = {r_q.bits[WIDTH-2:0], sin};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign q = r_q.bits;

endmodule

// File: rtl/adc_link_ctrl.sv
module adc_link_ctrl
    import adc_link_pkg::*;
#(
    parameter int SYS_CLK_KHZ = 250000,
    parameter int SCLK_KHZ    = 200,
    parameter int RES_BITS    = 12,
    parameter int GUARD_CYC   = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                cfg_single,
    input  logic                cfg_odd,
    output logic                busy,
    output logic [RES_BITS-1:0] result,
    output logic                result_valid,
    output logic                adc_cs_n,
    output logic                adc_sclk,
    output logic                sdio_out,
    output logic                sdio_oe,
    input  logic                sdio_in
);
    localparam int HALF         = half_cycles(SYS_CLK_KHZ, SCLK_KHZ);
    localparam int LAST_RISE    = CMD_LEN + NULL_LEN + RES_BITS;
    localparam int FIRST_SAMPLE = CMD_LEN + NULL_LEN + 1;
    localparam int RW           = $clog2(LAST_RISE + 1);
    localparam int GUARD_EFF    = (GUARD_CYC < 1) ? 1 : GUARD_CYC;
    localparam int GW           = (GUARD_EFF > 1) ? $clog2(GUARD_EFF) : 1;

    typedef struct packed {
        link_state_e   st;
        logic          cs_n;
        logic          sclk;
        logic          oe;
        logic [RW-1:0] rises;
        logic [GW-1:0] gcnt;
        logic          done;
        logic          valid;
    } ctrl_regs_t;

    ctrl_regs_t r_d, r_q;

    logic                tick;
    logic                cmd_load, cmd_shift;
    logic                rx_shift;
    logic [CMD_LEN-1:0]  cmd_bits;
    logic [RW-1:0]       rise_next;

    // Serial-clock level pacer
    adc_link_tick #(.HALF(HALF)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (r_q.st == LINK_RUN),
        .tick  (tick)
    );

    // Outgoing command: start marker, mode, channel, MSB-first request
    adc_link_shreg #(.WIDTH(CMD_LEN)) u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cmd_load),
        .load_val ({1'b1, cfg_single, cfg_odd, 1'b1}),
        .shift    (cmd_shift),
        .sin      (1'b0),
        .q        (cmd_bits)
    );

    // Incoming result word, most significant bit first
    adc_link_shreg #(.WIDTH(RES_BITS)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (1'b0),
        .load_val ('0),
        .shift    (rx_shift),
        .sin      (sdio_in),
        .q        (result)
    );

    assign rise_next = r_q.rises + 1'b1;

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        cmd_load  = 1'b0;
        cmd_shift = 1'b0;
        rx_shift  = 1'b0;

        unique case (r_q.st)
            LINK_IDLE: begin
                if (start) begin
                    r_d.st    = LINK_RUN;
                    r_d.cs_n  = 1'b0;
                    r_d.sclk  = 1'b0;
                    r_d.oe    = 1'b1;
                    r_d.rises = '0;
                    r_d.done  = 1'b0;
                    cmd_load  = 1'b1;
                end
            end

            LINK_RUN: begin
                // Turn the wire around once the fourth rising edge is out
                if (r_q.rises >= RW'(CMD_LEN)) begin
                    r_d.oe = 1'b0;
                end
                if (r_q.done) begin
                    r_d.st    = LINK_GUARD;
                    r_d.cs_n  = 1'b1;
                    r_d.sclk  = 1'b0;
                    r_d.oe    = 1'b0;
                    r_d.valid = 1'b1;
                    r_d.gcnt  = '0;
                end else if (tick) begin
                    if (!r_q.sclk) begin
                        r_d.sclk  = 1'b1;
                        r_d.rises = rise_next;
                        if (rise_next >= RW'(FIRST_SAMPLE)) begin
                            rx_shift = 1'b1;
                        end
                        if (rise_next == RW'(LAST_RISE)) begin
                            r_d.done = 1'b1;
                        end
                    end else begin
                        r_d.sclk = 1'b0;
                        if (r_q.rises < RW'(CMD_LEN)) begin
                            cmd_shift = 1'b1;
                        end
                    end
                end
            end

            LINK_GUARD: begin
                if (r_q.gcnt == GW'(GUARD_EFF - 1)) begin
                    r_d.st = LINK_IDLE;
                end else begin
                    r_d.gcnt = r_q.gcnt + 1'b1;
                end
            end

            default: begin
                r_d.st   = LINK_IDLE;
                r_d.cs_n = 1'b1;
                r_d.sclk = 1'b0;
                r_d.oe   = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= LINK_IDLE;
            r_q.cs_n  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy         = (r_q.st != LINK_IDLE);
    assign result_valid = r_q.valid;
    assign adc_cs_n     = r_q.cs_n;
    assign adc_sclk     = r_q.sclk;
    assign sdio_oe      = r_q.oe;
    assign sdio_out     = cmd_bits[CMD_LEN-1];

endmodule

// File: rtl/adc_link_chk.sv
module adc_link_chk #(
    parameter int HALF      = 2,
    parameter int LAST_RISE = 17,
    parameter int CMD_LEN   = 4,
    parameter int GUARD_CYC = 16
) (
    input logic clk,
    input logic rst_n,
    input logic adc_cs_n,
    input logic adc_sclk,
    input logic sdio_oe,
    input logic busy,
    input logic result_valid
);
    logic        sclk_p_q;
    logic [31:0] rise_cnt_q;
    logic [31:0] run_q;
    logic [31:0] gcnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_p_q   <= 1'b0;
            rise_cnt_q <= '0;
            run_q      <= '0;
            gcnt_q     <= 32'(GUARD_CYC);
        end else begin
            sclk_p_q <= adc_sclk;
            if (adc_cs_n) begin
                rise_cnt_q <= '0;
                run_q      <= '0;
                if (gcnt_q < 32'(GUARD_CYC)) gcnt_q <= gcnt_q + 1;
            end else begin
                gcnt_q <= '0;
                if (adc_sclk && !sclk_p_q) rise_cnt_q <= rise_cnt_q + 1;
                if (adc_sclk != sclk_p_q) run_q <= 32'd1;
                else                      run_q <= run_q + 1;
            end
        end
    end

    p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        adc_cs_n |-> (!adc_sclk && !sdio_oe));

    p_busy_when_selected_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_cs_n |-> busy);

    p_level_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!adc_cs_n && (adc_sclk != sclk_p_q)) |-> (run_q == 32'(HALF)));

    p_released_at_fall4_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!adc_cs_n && $fell(adc_sclk) && (rise_cnt_q >= 32'(CMD_LEN))) |-> !sdio_oe);

    p_no_extra_edges_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_cs_n |-> (rise_cnt_q <= 32'(LAST_RISE)));

    p_strobe_on_deselect_r8: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> $rose(adc_cs_n));

    p_guard_respected_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_cs_n) |-> (gcnt_q >= 32'(GUARD_CYC)));

endmodule

bind adc_link_ctrl adc_link_chk #(
    .HALF      (HALF),
    .LAST_RISE (LAST_RISE),
    .CMD_LEN   (adc_link_pkg::CMD_LEN),
    .GUARD_CYC (GUARD_EFF)
) u_link_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .adc_cs_n     (adc_cs_n),
    .adc_sclk     (adc_sclk),
    .sdio_oe      (sdio_oe),
    .busy         (busy),
    .result_valid (result_valid)
);

// File: tb/test_adc_link_ctrl.sv
`timescale 1ns/1ps
module test_adc_link_ctrl;
    localparam int SYS_KHZ = 4000;
    localparam int REQ_KHZ = 250;          // above the ceiling: must clamp
    localparam int RES     = 12;
    localparam int G       = 16;
    localparam int H       = 10;           // ceil(4000 / (2*200))
    localparam int LAST    = 4 + 1 + RES;  // 17 rising edges
    localparam int CS_END  = (2 * LAST - 1) * H;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic cfg_single = 1'b0;
    logic cfg_odd = 1'b0;
    logic busy, result_valid, adc_cs_n, adc_sclk, sdio_out, sdio_oe, sdio_in;
    logic [RES-1:0] result;

    always #2 clk = ~clk;  // 250 MHz

    adc_link_ctrl #(
        .SYS_CLK_KHZ (SYS_KHZ),
        .SCLK_KHZ    (REQ_KHZ),
        .RES_BITS    (RES),
        .GUARD_CYC   (G)
    ) i_adc_link_ctrl (
        .clk, .rst_n, .start, .cfg_single, .cfg_odd, .busy, .result,
        .result_valid, .adc_cs_n, .adc_sclk, .sdio_out, .sdio_oe, .sdio_in
    );

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit finished = 0;

    // Reference sequencer state
    int rt = -1;
    int accepts = 0;
    logic ref_sgl = 0, ref_odd = 0;
    logic [RES-1:0] ref_word = '0;
    logic [RES-1:0] word_q[$];

    // Converter model state
    logic c_prev = 0, c_drive = 0, c_bit = 0;
    int c_falls = 0, c_rises = 0;

    assign sdio_in = sdio_oe ? sdio_out : (c_drive ? c_bit : 1'b1);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h (time %0t)", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rt <= -1;
        end else if (rt < 0) begin
            if (start) begin
                rt <= 0;
                accepts <= accepts + 1;
                ref_sgl <= cfg_single;
                ref_odd <= cfg_odd;
                ref_word <= (word_q.size() > 0) ? word_q.pop_front() : '0;
            end
        end else if (rt == CS_END + G) begin
            rt <= -1;
        end else begin
            rt <= rt + 1;
        end
    end

    always @(negedge clk) begin
        logic exp_cs, exp_sclk, exp_oe, exp_busy, exp_valid, exp_bit;
        logic [3:0] cmd;
        int idx;
        cyc++;
        exp_cs    = !(rt >= 0 && rt <= CS_END);
        exp_sclk  = (rt >= 0 && rt <= CS_END) && (((rt / H) % 2) == 1);
        exp_oe    = (rt >= 0 && rt <= 7 * H);
        exp_busy  = (rt >= 0);
        exp_valid = (rt == CS_END + 1);
        cmd = {1'b1, ref_sgl, ref_odd, 1'b1};
        if (!rst_n) begin
            chk("R1", {adc_cs_n, adc_sclk, sdio_oe, busy, result_valid}, 5'b10000);
        end else begin
            chk("R2 R7 R9", adc_cs_n, exp_cs);
            chk("R4", adc_sclk, exp_sclk);
            chk("R5", sdio_oe, exp_oe);
            chk("R9 R10", busy, exp_busy);
            chk("R8", result_valid, exp_valid);
            if (exp_valid) chk("R6", result, ref_word);
            if (exp_oe) begin
                idx = rt / (2 * H);
                if (idx > 3) idx = 3;
                chk("R3", sdio_out, cmd[3 - idx]);
            end
            chk("R5", c_drive & sdio_oe, 0);
        end
        // Converter model: reacts to the observed pins
        if (adc_cs_n) begin
            c_falls = 0;
            c_rises = 0;
            c_drive = 0;
        end else begin
            if (c_prev && !adc_sclk) begin
                c_falls++;
                if (c_falls >= 4) c_drive = 1;
                if (c_falls == 4) c_bit = 0;
                else if (c_falls <= LAST - 1) c_bit = ref_word[LAST - 1 - c_falls];
                else c_bit = 0;
            end
            if (!c_prev && adc_sclk) begin
                c_rises++;
                if (c_rises <= 4) begin
                    exp_bit = cmd[4 - c_rises];
                    chk("R3 R11", sdio_in, exp_bit);
                end
            end
        end
        c_prev = adc_sclk;
        if (cyc > 100000 && !finished) begin
            finished = 1;
            fails++;
            $display("FAIL watchdog: actual=%0d expected=<100000 cycles", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic wait_idle();
        while (rt >= 0) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // Single-ended, even channel
        word_q.push_back(12'hA5C);
        cfg_single = 1; cfg_odd = 0; start = 1;
        @(negedge clk); start = 0;
        wait_idle();
        repeat (5) @(negedge clk);

        // Differential with late config change and requests while busy
        word_q.push_back(12'h801);
        cfg_single = 0; cfg_odd = 1; start = 1;
        @(negedge clk); start = 0;
        repeat (5) @(negedge clk);
        cfg_single = 1; cfg_odd = 0;       // R11: must not alter command
        repeat (40) @(negedge clk);
        start = 1; @(negedge clk); start = 0;   // R9: ignored mid-run
        while (!adc_cs_n) @(negedge clk);
        repeat (3) @(negedge clk);
        start = 1; @(negedge clk); start = 0;   // R10: ignored in guard
        wait_idle();
        repeat (7) @(negedge clk);

        // Held request: back-to-back at the guard boundary
        word_q.push_back(12'h000);
        word_q.push_back(12'hFFF);
        word_q.push_back(12'h3C6);
        cfg_single = 1; cfg_odd = 1;
        begin
            int base;
            base = accepts;
            start = 1;
            while (accepts < base + 3) @(negedge clk);
            start = 0;
        end
        wait_idle();
        repeat (10) @(negedge clk);

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule